// File: doc/BRIEF.md
# SPI ADC Transaction Engine

This block is an SPI master that runs one transaction at a time against a delta-sigma converter that takes byte commands. A request carries a kind (command only, register write, register read or conversion-data read), a 4-bit register address and one data byte. The engine frames the whole exchange with chip select. It shifts the command bytes out MSB first and, for the two read kinds, waits a turnaround time before it clocks the response back in. It ends the transaction with a one-cycle done pulse that presents the received byte or the 24-bit conversion word.

The turnaround time is set at run time. The oscillator period of the converter, given as a count of system clocks, is multiplied by a fixed factor (50 by default). The SCLK rate comes from a programmable half-period count. The host must keep both inputs steady while a transaction is running.

Top module: `adcSpiEngine`

## Requirements
- R1: `csN` goes low when a request is accepted and stays low until the last SCLK edge of the transaction. It is high whenever `busy` is low. SCLK idles low and toggles only while `csN` is low.
- R2: SPI mode 0 is used, MSB first. MOSI changes only after a falling SCLK edge and stays stable while SCLK is high. MISO is sampled on the rising edge. Each SCLK half-period lasts `clkDiv`+1 system clocks.
- R3: Kind 0 (command only) sends exactly one byte equal to `reqData`.
- R4: Kind 1 (register write) sends three bytes: 0x50 ORed with the address, then a count byte of 0x00 (one register), then `reqData`.
- R5: Kind 2 (register read) sends 0x10 ORed with the address, then 0x00. After the turnaround it clocks one byte in while MOSI carries 0xFF. That byte appears on `rdByte`, and `rdResult` reads {16'h0, byte}.
- R6: Kind 3 (data read) sends 0x01. After the turnaround it clocks in three bytes while MOSI carries 0xFF. `rdResult` is the first byte received in bits 23:16, the second in bits 15:8 and the third in bits 7:0.
- R7: For the read kinds, the time from the last falling SCLK edge of the command bytes to the first rising SCLK edge of the response is at least 50×`oscCycles` clocks, and at most 50×`oscCycles`+`clkDiv`+8 clocks.
- R8: Command-only and write transactions insert no turnaround. In a write, consecutive bytes are separated by at most `clkDiv`+4 clocks.
- R9: `busy` rises in the cycle after a request is accepted and falls in the cycle in which `done` pulses. `done` lasts exactly one cycle and comes with `csN` high and the results valid. Command-only and write transactions report a result of zero.
- R10: A request presented while `busy` is high is ignored: it starts no frame and sends no byte.
- R11: During and after reset, `csN` is 1, `sclk` is 0, and `busy`, `done` and `rdResult` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqType | input | 2 | Request kind: 0 command, 1 register write, 2 register read, 3 data read |
| reqAddr | input | 4 | Register address for write or read |
| reqData | input | 8 | Opcode for command kind, data byte for write kind |
| oscCycles | input | OSC_W | Converter oscillator period in system clocks |
| clkDiv | input | DIV_W | SCLK half-period minus one, in system clocks |
| miso | input | 1 | Serial data from converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to converter |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdByte | output | 8 | Received register byte |
| rdResult | output | 24 | Assembled response word |

## Verification
Each of the four request kinds is run against a modelled converter. The converter returns distinct byte patterns, such as 0xA5, 0x123456, 0xFEDCBA and 0x81, so that a swapped byte order, a lost bit or an LSB-first shift gives a wrong word. The reads are repeated with several oscillator counts and divider settings, including both set to zero. The measured gap before the response separates a missing or short turnaround from a correct one. The same gap measured inside a write exposes a turnaround that was wrongly applied. A request injected in the middle of a write shows whether busy requests are filtered, because it would add an unexpected frame or byte.

// File: rtl/adcSpiPkg.sv
package adcSpiPkg;

  typedef enum logic [1:0] {
    REQ_CMD   = 2'd0,
    REQ_WREG  = 2'd1,
    REQ_RREG  = 2'd2,
    REQ_RDATA = 2'd3
  } reqKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       startByte;
    logic [7:0] txByte;
    logic       startWait;
    logic       capByte;
    logic       clrRes;
  } dpCtl_t;

endpackage

// File: rtl/adcSpiDatapath.sv
module adcSpiDatapath
  import adcSpiPkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int OSC_W     = 12,
  parameter int TURN_MULT = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [OSC_W-1:0]  oscCycles,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              byteDone,
  output logic              waitDone,
  output logic [23:0]       result
);

  localparam int WAIT_W = OSC_W + $clog2(TURN_MULT + 1);

  logic             active;
  logic [DIV_W-1:0] halfCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic             sclkR;
  logic             mosiR;
  logic             tick;
  logic             waiting;
  logic [WAIT_W-1:0] waitCnt;

  assign tick = active && (halfCnt == clkDiv);
  assign sclk = sclkR;
  assign mosi = mosiR;

  // byte shifter and SCLK generation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      halfCnt  <= '0;
      bitCnt   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      sclkR    <= 1'b0;
      mosiR    <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctl.startByte) begin
        active  <= 1'b1;
        halfCnt <= '0;
        bitCnt  <= '0;
        sclkR   <= 1'b0;
        mosiR   <= ctl.txByte[7];
        txSh    <= {ctl.txByte[6:0], 1'b0};
      end else if (active) begin
        if (tick) begin
          halfCnt <= '0;
          if (!sclkR) begin
            sclkR <= 1'b1;
            rxSh  <= {rxSh[6:0], miso};
          end else begin
            sclkR <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              mosiR  <= txSh[7];
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  // turnaround timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waiting  <= 1'b0;
      waitCnt  <= '0;
      waitDone <= 1'b0;
    end else begin
      waitDone <= 1'b0;
      if (ctl.startWait) begin
        waiting <= 1'b1;
        waitCnt <= WAIT_W'(oscCycles) * WAIT_W'(TURN_MULT);
      end else if (waiting) begin
        if (waitCnt == '0) begin
          waiting  <= 1'b0;
          waitDone <= 1'b1;
        end else begin
          waitCnt <= waitCnt - 1'b1;
        end
      end
    end
  end

  // response assembly, first byte lands in the top
  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
    end else if (ctl.clrRes) begin
      result <= '0;
    end else if (ctl.capByte) begin
      result <= {result[15:0], rxSh};
    end
  end

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R2
  AST_NO_CLK_IN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    waiting |-> (!active && !sclk)); // R7
  AST_BYTE_END_LOW: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> !sclk); // R2

endmodule

// File: rtl/adcSpiCtrl.sv
module adcSpiCtrl
  import adcSpiPkg::*;
#(
  parameter logic [7:0] WREG_OP    = 8'h50,
  parameter logic [7:0] RREG_OP    = 8'h10,
  parameter logic [7:0] RDATA_OP   = 8'h01,
  parameter logic [7:0] COUNT_BYTE = 8'h00,
  parameter logic [7:0] FILL_BYTE  = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqType,
  input  logic [3:0] reqAddr,
  input  logic [7:0] reqData,
  input  logic       byteDone,
  input  logic       waitDone,
  output dpCtl_t     ctl,
  output logic       csN,
  output logic       busy,
  output logic       done
);

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX} state_e;

  state_e     state;
  reqKind_e   kind;
  logic [3:0] addrR;
  logic [7:0] dataR;
  logic [1:0] idx;
  logic       accept;

  function automatic logic [7:0] cmdByte(reqKind_e k, logic [1:0] i,
                                         logic [3:0] a, logic [7:0] d);
    case (k)
      REQ_CMD:   cmdByte = d;
      REQ_WREG:  cmdByte = (i == 2'd0) ? (WREG_OP | {4'b0, a}) :
                           (i == 2'd1) ? COUNT_BYTE : d;
      REQ_RREG:  cmdByte = (i == 2'd0) ? (RREG_OP | {4'b0, a}) : COUNT_BYTE;
      default:   cmdByte = RDATA_OP;
    endcase
  endfunction

  function automatic logic [1:0] txLast(reqKind_e k);
    case (k)
      REQ_WREG: txLast = 2'd2;
      REQ_RREG: txLast = 2'd1;
      default:  txLast = 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] rxCount(reqKind_e k);
    case (k)
      REQ_RREG:  rxCount = 2'd1;
      REQ_RDATA: rxCount = 2'd3;
      default:   rxCount = 2'd0;
    endcase
  endfunction

  assign accept = reqValid && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE: if (accept) begin
        ctl.startByte = 1'b1;
        ctl.txByte    = cmdByte(reqKind_e'(reqType), 2'd0, reqAddr, reqData);
        ctl.clrRes    = 1'b1;
      end
      ST_TX: if (byteDone) begin
        if (idx == txLast(kind)) begin
          ctl.startWait = (rxCount(kind) != 2'd0);
        end else begin
          ctl.startByte = 1'b1;
          ctl.txByte    = cmdByte(kind, idx + 2'd1, addrR, dataR);
        end
      end
      ST_WAIT: if (waitDone) begin
        ctl.startByte = 1'b1;
        ctl.txByte    = FILL_BYTE;
      end
      ST_RX: if (byteDone) begin
        ctl.capByte = 1'b1;
        if (idx != rxCount(kind) - 2'd1) begin
          ctl.startByte = 1'b1;
          ctl.txByte    = FILL_BYTE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= REQ_CMD;
      addrR <= '0;
      dataR <= '0;
      idx   <= '0;
      csN   <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_TX;
          kind  <= reqKind_e'(reqType);
          addrR <= reqAddr;
          dataR <= reqData;
          idx   <= '0;
          csN   <= 1'b0;
        end
        ST_TX: if (byteDone) begin
          if (idx == txLast(kind)) begin
            idx <= '0;
            if (rxCount(kind) != 2'd0) begin
              state <= ST_WAIT;
            end else begin
              state <= ST_IDLE;
              csN   <= 1'b1;
              done  <= 1'b1;
            end
          end else begin
            idx <= idx + 2'd1;
          end
        end
        ST_WAIT: if (waitDone) begin
          state <= ST_RX;
        end
        ST_RX: if (byteDone) begin
          if (idx == rxCount(kind) - 2'd1) begin
            state <= ST_IDLE;
            csN   <= 1'b1;
            done  <= 1'b1;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_READS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (kind == REQ_RREG || kind == REQ_RDATA)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R9
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN); // R1

endmodule

// File: rtl/adcSpiEngine.sv
module adcSpiEngine
  import adcSpiPkg::*;
#(
  parameter int         DIV_W     = 8,
  parameter int         OSC_W     = 12,
  parameter int         TURN_MULT = 50,
  parameter logic [7:0] WREG_OP   = 8'h50,
  parameter logic [7:0] RREG_OP   = 8'h10,
  parameter logic [7:0] RDATA_OP  = 8'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqType,
  input  logic [3:0]       reqAddr,
  input  logic [7:0]       reqData,
  input  logic [OSC_W-1:0] oscCycles,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             miso,
  output logic             csN,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rdByte,
  output logic [23:0]      rdResult
);

  dpCtl_t ctl;
  logic   byteDone;
  logic   waitDone;

  adcSpiCtrl #(
    .WREG_OP  (WREG_OP),
    .RREG_OP  (RREG_OP),
    .RDATA_OP (RDATA_OP)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqType  (reqType),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .byteDone (byteDone),
    .waitDone (waitDone),
    .ctl      (ctl),
    .csN      (csN),
    .busy     (busy),
    .done     (done)
  );

  adcSpiDatapath #(
    .DIV_W     (DIV_W),
    .OSC_W     (OSC_W),
    .TURN_MULT (TURN_MULT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .clkDiv    (clkDiv),
    .oscCycles (oscCycles),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .byteDone  (byteDone),
    .waitDone  (waitDone),
    .result    (rdResult)
  );

  assign rdByte = rdResult[7:0];

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN); // R1
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !sclk)); // R9

endmodule

// File: tb/adcSpiEngine_bench.sv
module adcSpiEngine_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqType = '0;
  logic [3:0]  reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic [11:0] oscCycles = '0;
  logic [7:0]  clkDiv = '0;
  logic        miso;
  logic        csN, sclk, mosi, busy, done;
  logic [7:0]  rdByte;
  logic [23:0] rdResult;

  always #5 clk = ~clk;

  adcSpiEngine u_adcSpiEngine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .reqData(reqData), .oscCycles(oscCycles),
    .clkDiv(clkDiv), .miso(miso), .csN(csN), .sclk(sclk), .mosi(mosi),
    .busy(busy), .done(done), .rdByte(rdByte), .rdResult(rdResult)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  logic [7:0]  expMosiQ[$];
  logic [23:0] expResQ[$];
  string       curReq = "R3";

  // converter model state
  logic [23:0] slaveResp = '0;
  logic [23:0] respSh = '0;
  int          slaveCmdBits = 8;
  int          slaveGapIdx = 1000;
  int          lastGap = -1;
  int          riseCnt = 0;
  int          lastFall = 0;
  int          frames = 0;
  int          expFrames = 0;
  logic        prevSclk = 1'b0;
  logic        prevCsN = 1'b1;
  logic [7:0]  mosiSh = '0;
  logic [7:0]  expB;
  logic [23:0] expR;

  assign miso = respSh[23];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: converter model plus scoreboard compare
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevCsN && !csN) begin
        frames++;
        riseCnt = 0;
        respSh  = slaveResp;
      end
      if (sclk && !prevSclk) begin
        mosiSh = {mosiSh[6:0], mosi};
        riseCnt++;
        if (riseCnt == slaveGapIdx + 1) lastGap = cyc - lastFall;
        if (riseCnt % 8 == 0) begin
          if (expMosiQ.size() == 0) begin
            check(0, "R10", "unexpected MOSI byte", mosiSh, 0);
          end else begin
            expB = expMosiQ.pop_front();
            check(mosiSh == expB, curReq, "MOSI byte", mosiSh, expB);
          end
        end
      end
      if (!sclk && prevSclk) begin
        lastFall = cyc;
        if (riseCnt > slaveCmdBits) respSh = {respSh[22:0], 1'b1};
      end
      if (done) begin
        if (expResQ.size() == 0) begin
          check(0, "R10", "unexpected done", rdResult, 0);
        end else begin
          expR = expResQ.pop_front();
          check(rdResult == expR, curReq, "rdResult", rdResult, expR);
          check(rdByte == expR[7:0], curReq, "rdByte", rdByte, expR[7:0]);
        end
      end
    end
    prevSclk = sclk;
    prevCsN  = csN;
  end

  // driver: push expected items, issue the request, wait for completion
  task automatic runTxn(int kind, logic [3:0] addr, logic [7:0] data,
                        logic [23:0] resp, int osc, int div, string tag,
                        bit interfere);
    int turn;
    turn = 50 * osc;
    oscCycles = 12'(osc);
    clkDiv    = 8'(div);
    curReq    = tag;
    lastGap   = -1;
    case (kind)
      0: begin
        slaveCmdBits = 8; slaveGapIdx = 1000; slaveResp = '0;
        expMosiQ.push_back(data);
        expResQ.push_back(24'h0);
      end
      1: begin
        slaveCmdBits = 24; slaveGapIdx = 8; slaveResp = '0;
        expMosiQ.push_back(8'h50 | {4'h0, addr});
        expMosiQ.push_back(8'h00);
        expMosiQ.push_back(data);
        expResQ.push_back(24'h0);
      end
      2: begin
        slaveCmdBits = 16; slaveGapIdx = 16; slaveResp = {resp[7:0], 16'hFFFF};
        expMosiQ.push_back(8'h10 | {4'h0, addr});
        expMosiQ.push_back(8'h00);
        expMosiQ.push_back(8'hFF);
        expResQ.push_back({16'h0, resp[7:0]});
      end
      default: begin
        slaveCmdBits = 8; slaveGapIdx = 8; slaveResp = resp;
        expMosiQ.push_back(8'h01);
        expMosiQ.push_back(8'hFF);
        expMosiQ.push_back(8'hFF);
        expMosiQ.push_back(8'hFF);
        expResQ.push_back(resp);
      end
    endcase
    expFrames++;
    @(negedge clk);
    reqValid = 1'b1;
    reqType  = 2'(kind);
    reqAddr  = addr;
    reqData  = data;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R9", "busy after accept", busy, 1);
    check(csN == 1'b0, "R1", "csN after accept", csN, 0);
    if (interfere) begin
      repeat (5) @(negedge clk);
      reqValid = 1'b1;
      reqType  = 2'd0;
      reqData  = 8'h99;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (!done) @(negedge clk);
    check(busy == 1'b0 && csN == 1'b1, "R9", "busy/csN at done", {busy, csN}, 2'b01);
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", done, 0);
    check(expMosiQ.size() == 0, tag, "bytes left unsent", expMosiQ.size(), 0);
    check(frames == expFrames, "R10", "frame count", frames, expFrames);
    if (kind == 2 || kind == 3) begin
      check(lastGap >= turn, "R7", "turnaround min", lastGap, turn);
      check(lastGap <= turn + div + 8, "R7", "turnaround max", lastGap, turn + div + 8);
    end
    if (kind == 1) begin
      check(lastGap >= 0 && lastGap <= div + 4, "R8", "write byte gap", lastGap, div + 4);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(csN == 1'b1, "R11", "csN in reset", csN, 1);
    check(sclk == 1'b0, "R11", "sclk in reset", sclk, 0);
    check(busy == 1'b0 && done == 1'b0, "R11", "busy/done in reset", {busy, done}, 0);
    check(rdResult == 24'h0, "R11", "result in reset", rdResult, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b0, "R1", "idle lines", {csN, sclk}, 2'b10);

    runTxn(0, 4'h0, 8'hFE, 24'h0, 2, 1, "R3", 0);
    runTxn(1, 4'h5, 8'h3C, 24'h0, 3, 1, "R4", 0);
    runTxn(2, 4'hA, 8'h00, 24'h0000A5, 2, 1, "R5", 0);
    runTxn(3, 4'h0, 8'h00, 24'h123456, 2, 2, "R6", 0);
    runTxn(3, 4'h0, 8'h00, 24'hFEDCBA, 0, 0, "R6", 0);
    runTxn(2, 4'hF, 8'h00, 24'h000081, 1, 3, "R5", 0);
    runTxn(1, 4'h0, 8'hC3, 24'h0, 4, 0, "R10", 1);
    runTxn(0, 4'h0, 8'h00, 24'h0, 1, 2, "R3", 0);
    runTxn(3, 4'h0, 8'h00, 24'h80017F, 1, 1, "R2", 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule